// File: doc/BRIEF.md
# Privileged Alternate-Space Move Unit

This unit carries out one supervisor-only transfer between a CPU register and memory. The memory access is tagged with a software-chosen function code, not with the current privilege. It holds two 3-bit function-code registers: one tags loads (the source code) and one tags stores (the destination code). A caller presents an opcode word, one extension word and the current supervisor flag with a one-cycle `start`. The unit then reads the base address register and the transfer register through a single register-file port. It issues one memory request that is held until `ready`, writes the results back one register per cycle and pulses `done`.

Only address-register indirect addressing is handled, in its plain, postincrement and predecrement forms. A user-mode issue, a bad encoding or any other addressing mode ends in a one-cycle exception pulse. In that case there is no memory traffic and no register write.

Top module: `altspace_move_unit`

## Requirements
- R1: Both function-code registers reset to 0. A write (`fcr_sel` 0 = source, 1 = destination) keeps only the low 3 bits of `fcr_wdata`, and `fcr_rdata` returns the stored 3-bit value of the register chosen by `fcr_sel`.
- R2: A `start` accepted while `supervisor` is 0 pulses `exc_priv` for one cycle, in the cycle after the accepting edge. No memory request and no register write follow. This check takes priority over every other fault.
- R3: Extension bit 15 selects the transfer register class (1 = address, 0 = data) and bits 14:12 give its number. On both register-file ports the index is {class, number}, so indices 8..15 are address registers.
- R4: Extension bit 11 = 1 stores the transfer register to memory (`mem_write` = 1, `mem_wdata` = register value, `mem_fc` = destination code). Bit 11 = 0 loads memory into the register with `mem_fc` = source code. The code is sampled when `start` is accepted.
- R5: `mem_super` equals bit 2 of the function code that tags the access (1 = supervisor space, 0 = user space).
- R6: A byte or word load into an address register is sign-extended to 32 bits.
- R7: A byte or word load into a data register replaces only bits 7:0 or 15:0 and keeps the upper bits. A long load replaces all 32 bits.
- R8: Opcode mode 011 (postincrement) accesses the base address, then writes base + step back to the address register. The step is 1/2/4 for byte/word/long, except a byte access through register 7, which steps by 2.
- R9: Opcode mode 100 (predecrement) accesses base − step (same step rule) and writes that address back. Mode 010 (plain indirect) accesses the base and writes no address register.
- R10: The opcode is valid when `opcode & 16'hFF00 == 16'h0E00`. Bits 7:6 encode size (00 byte, 01 word, 10 long), which `mem_size` repeats, and bits 5:3 / 2:0 give mode and address register. A supervisor issue with a non-matching opcode or size 11 pulses `exc_illegal` with no side effects.
- R11: A valid supervisor issue whose mode is not 010, 011 or 100 pulses `exc_addr_mode` with no side effects.
- R12: `mem_req` and its address, size, direction and code stay stable until `mem_ready`. A load's register write comes in the cycle after ready, the address write-back (if any) follows, and then `done` pulses for exactly one cycle. `start` is ignored while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcr_wr_en | input | 1 | Write strobe for a function-code register |
| fcr_sel | input | 1 | 0 = source code, 1 = destination code |
| fcr_wdata | input | DATA_W | Write value (low 3 bits kept) |
| fcr_rdata | output | FC_W | Value of the selected code register |
| start | input | 1 | Issue strobe |
| opcode | input | 16 | Opcode word |
| ext_word | input | 16 | Extension word |
| supervisor | input | 1 | Current supervisor flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| exc_priv | output | 1 | Privilege violation pulse |
| exc_illegal | output | 1 | Illegal instruction pulse |
| exc_addr_mode | output | 1 | Unsupported addressing mode pulse |
| rf_rd_addr | output | 4 | Register-file read index |
| rf_rd_data | input | DATA_W | Register-file read data (same cycle) |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_addr | output | 4 | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_size | output | 2 | Access size code |
| mem_fc | output | FC_W | Function code tagging the access |
| mem_super | output | 1 | Supervisor-space access |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Load data, valid with ready |
| mem_ready | input | 1 | Memory completion |

## Verification
A corrupted latched opcode or extension field shows up on the memory port within three cycles of `start`, as a wrong address, size, direction or code on the first request cycle. A wrong step or merge stays hidden until the write-back cycles. It then appears as a wrong value in the register file, one or two cycles after ready. A sequencing fault shows as a missing, doubled or early `done`, or as an exception pulse that is not in the cycle right after issue. Each transfer is therefore judged on its request fields, on the final register contents and on its pulse count.

// File: rtl/amu_pkg.sv
package amu_pkg;

   localparam logic [15:0] AMU_OPC_MASK  = 16'hFF00;
   localparam logic [15:0] AMU_OPC_MATCH = 16'h0E00;

   localparam logic [2:0] AMU_MODE_IND  = 3'b010;
   localparam logic [2:0] AMU_MODE_POST = 3'b011;
   localparam logic [2:0] AMU_MODE_PRE  = 3'b100;

   typedef enum logic [1:0] {
      AMU_SZ_BYTE = 2'b00,
      AMU_SZ_WORD = 2'b01,
      AMU_SZ_LONG = 2'b10,
      AMU_SZ_BAD  = 2'b11
   } amu_size_e;

   typedef enum logic [1:0] {
      AMU_FLT_NONE,
      AMU_FLT_PRIV,
      AMU_FLT_ILLEGAL,
      AMU_FLT_MODE
   } amu_fault_e;

   typedef enum logic [2:0] {
      AMU_ST_IDLE,
      AMU_ST_EXC,
      AMU_ST_RD_ADDR,
      AMU_ST_RD_DATA,
      AMU_ST_MEM,
      AMU_ST_WB_REG,
      AMU_ST_WB_ADDR,
      AMU_ST_DONE
   } amu_state_e;

   typedef struct packed {
      logic       store;
      logic       xfer_is_areg;
      logic [2:0] xfer_num;
      amu_size_e  size;
      logic [2:0] mode;
      logic [2:0] base_num;
   } amu_op_t;

endpackage

// File: rtl/amu_fc_regs.sv
module amu_fc_regs #(
   parameter int DATA_W = 32,
   parameter int FC_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [FC_W-1:0]   rd_fc,
   output logic [FC_W-1:0]   src_fc,
   output logic [FC_W-1:0]   dst_fc
);
   localparam int NUM_REGS = 2;

   logic [NUM_REGS-1:0][FC_W-1:0] fc_q;
   logic unused_wdata_hi;

   assign unused_wdata_hi = ^wdata[DATA_W-1:FC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fc_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == i[0]) fc_q[i] <= wdata[FC_W-1:0];
         end
      end
   end

   assign src_fc = fc_q[0];
   assign dst_fc = fc_q[1];
   assign rd_fc  = fc_q[sel];

   a_r1_src_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel) |=> (src_fc == $past(wdata[FC_W-1:0])));
   a_r1_dst_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel) |=> (dst_fc == $past(wdata[FC_W-1:0])));

endmodule

// File: rtl/amu_decode.sv
module amu_decode
   import amu_pkg::*;
(
   input  logic [15:0] opcode,
   input  logic [15:0] ext_word,
   input  logic        supervisor,
   output amu_op_t     op,
   output amu_fault_e  fault
);
   logic opc_hit;
   logic mode_ok;
   logic unused_ext_lo;

   assign unused_ext_lo = ^ext_word[10:0];
   assign opc_hit = ((opcode & AMU_OPC_MASK) == AMU_OPC_MATCH);

   always_comb begin
      op.store        = ext_word[11];
      op.xfer_is_areg = ext_word[15];
      op.xfer_num     = ext_word[14:12];
      op.size         = amu_size_e'(opcode[7:6]);
      op.mode         = opcode[5:3];
      op.base_num     = opcode[2:0];
   end

   always_comb begin
      unique case (op.mode)
         AMU_MODE_IND, AMU_MODE_POST, AMU_MODE_PRE: mode_ok = 1'b1;
         default:                                   mode_ok = 1'b0;
      endcase
   end

   // Priority: privilege, then encoding, then addressing mode
   always_comb begin
      if (!supervisor)                         fault = AMU_FLT_PRIV;
      else if (!opc_hit || op.size == AMU_SZ_BAD) fault = AMU_FLT_ILLEGAL;
      else if (!mode_ok)                       fault = AMU_FLT_MODE;
      else                                     fault = AMU_FLT_NONE;
   end

endmodule

// File: rtl/amu_agen.sv
module amu_agen
   import amu_pkg::*;
#(
   parameter int ADDR_W          = 32,
   parameter int STACK_REG       = 7,
   parameter int STACK_BYTE_STEP = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [2:0]        mode,
   input  amu_size_e         size,
   input  logic [2:0]        base_num,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] an_next
);
   localparam logic [2:0]        SP_NUM   = STACK_REG[2:0];
   localparam logic [ADDR_W-1:0] SP_STEP  = ADDR_W'(STACK_BYTE_STEP);
   localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TWO      = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] FOUR     = ADDR_W'(4);

   logic [ADDR_W-1:0] byte_step;
   logic [ADDR_W-1:0] step;

   generate
      if (STACK_BYTE_STEP == 1) begin : g_plain_byte
         assign byte_step = ONE;
      end else begin : g_aligned_stack
         assign byte_step = (base_num == SP_NUM) ? SP_STEP : ONE;
      end
   endgenerate

   always_comb begin
      unique case (size)
         AMU_SZ_BYTE: step = byte_step;
         AMU_SZ_WORD: step = TWO;
         default:     step = FOUR;
      endcase
   end

   assign ea      = (mode == AMU_MODE_PRE)  ? (base - step) : base;
   assign an_next = (mode == AMU_MODE_POST) ? (base + step) : ea;

endmodule

// File: rtl/amu_load_merge.sv
module amu_load_merge
   import amu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  amu_size_e         size,
   input  logic              to_areg,
   input  logic [DATA_W-1:0] mem_data,
   input  logic [DATA_W-1:0] old_val,
   output logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] byte_res;
   logic [DATA_W-1:0] word_res;
   logic [DATA_W-1:0] long_res;

   assign byte_res = to_areg ? {{(DATA_W-8){mem_data[7]}}, mem_data[7:0]}
                             : {old_val[DATA_W-1:8], mem_data[7:0]};
   assign word_res = to_areg ? {{(DATA_W-16){mem_data[15]}}, mem_data[15:0]}
                             : {old_val[DATA_W-1:16], mem_data[15:0]};

   generate
      if (DATA_W == 32) begin : g_long_full
         assign long_res = mem_data;
      end else begin : g_long_wide
         assign long_res = to_areg ? {{(DATA_W-32){mem_data[31]}}, mem_data[31:0]}
                                   : {old_val[DATA_W-1:32], mem_data[31:0]};
      end
   endgenerate

   always_comb begin
      unique case (size)
         AMU_SZ_BYTE: result = byte_res;
         AMU_SZ_WORD: result = word_res;
         default:     result = long_res;
      endcase
   end

endmodule

// File: rtl/altspace_move_unit.sv
module altspace_move_unit
   import amu_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int ADDR_W          = 32,
   parameter int FC_W            = 3,
   parameter int FC_SPACE_BIT    = 2,
   parameter int STACK_REG       = 7,
   parameter int STACK_BYTE_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fcr_wr_en,
   input  logic              fcr_sel,
   input  logic [DATA_W-1:0] fcr_wdata,
   output logic [FC_W-1:0]   fcr_rdata,
   input  logic              start,
   input  logic [15:0]       opcode,
   input  logic [15:0]       ext_word,
   input  logic              supervisor,
   output logic              busy,
   output logic              done,
   output logic              exc_priv,
   output logic              exc_illegal,
   output logic              exc_addr_mode,
   output logic [3:0]        rf_rd_addr,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [3:0]        rf_wr_addr,
   output logic [DATA_W-1:0] rf_wr_data,
   output logic              mem_req,
   output logic              mem_write,
   output logic [1:0]        mem_size,
   output logic [FC_W-1:0]   mem_fc,
   output logic              mem_super,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   localparam int ADDR_PAD = DATA_W - ADDR_W;

   initial begin : p_param_check
      assert (DATA_W >= 32) else $fatal(1, "DATA_W must be at least 32");
      assert (ADDR_W >= 8 && ADDR_W <= DATA_W) else $fatal(1, "ADDR_W out of range");
      assert (FC_SPACE_BIT < FC_W) else $fatal(1, "FC_SPACE_BIT outside code");
      assert (STACK_REG >= 0 && STACK_REG < 8) else $fatal(1, "STACK_REG out of range");
      assert (STACK_BYTE_STEP >= 1) else $fatal(1, "STACK_BYTE_STEP must be positive");
   end

   amu_state_e        state_q;
   amu_op_t           op_q;
   amu_fault_e        fault_q;
   logic [FC_W-1:0]   fc_q;
   logic [ADDR_W-1:0] ea_q;
   logic [ADDR_W-1:0] an_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] rdata_q;

   amu_op_t           dec_op;
   amu_fault_e        dec_fault;
   logic [FC_W-1:0]   src_fc;
   logic [FC_W-1:0]   dst_fc;
   logic [ADDR_W-1:0] ag_ea;
   logic [ADDR_W-1:0] ag_next;
   logic [DATA_W-1:0] load_res;
   logic              has_addr_wb;

   amu_fc_regs #(.DATA_W(DATA_W), .FC_W(FC_W)) fc_regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (fcr_wr_en),
      .sel    (fcr_sel),
      .wdata  (fcr_wdata),
      .rd_fc  (fcr_rdata),
      .src_fc (src_fc),
      .dst_fc (dst_fc)
   );

   amu_decode decode_i (
      .opcode     (opcode),
      .ext_word   (ext_word),
      .supervisor (supervisor),
      .op         (dec_op),
      .fault      (dec_fault)
   );

   amu_agen #(
      .ADDR_W          (ADDR_W),
      .STACK_REG       (STACK_REG),
      .STACK_BYTE_STEP (STACK_BYTE_STEP)
   ) agen_i (
      .base     (rf_rd_data[ADDR_W-1:0]),
      .mode     (op_q.mode),
      .size     (op_q.size),
      .base_num (op_q.base_num),
      .ea       (ag_ea),
      .an_next  (ag_next)
   );

   amu_load_merge #(.DATA_W(DATA_W)) merge_i (
      .size     (op_q.size),
      .to_areg  (op_q.xfer_is_areg),
      .mem_data (rdata_q),
      .old_val  (data_q),
      .result   (load_res)
   );

   assign has_addr_wb = (op_q.mode != AMU_MODE_IND);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= AMU_ST_IDLE;
         op_q    <= '0;
         fault_q <= AMU_FLT_NONE;
         fc_q    <= '0;
         ea_q    <= '0;
         an_q    <= '0;
         data_q  <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state_q)
            AMU_ST_IDLE: begin
               if (start) begin
                  op_q    <= dec_op;
                  fc_q    <= dec_op.store ? dst_fc : src_fc;
                  fault_q <= dec_fault;
                  state_q <= (dec_fault != AMU_FLT_NONE) ? AMU_ST_EXC : AMU_ST_RD_ADDR;
               end
            end
            AMU_ST_EXC: state_q <= AMU_ST_IDLE;
            AMU_ST_RD_ADDR: begin
               ea_q    <= ag_ea;
               an_q    <= ag_next;
               state_q <= AMU_ST_RD_DATA;
            end
            AMU_ST_RD_DATA: begin
               data_q  <= rf_rd_data;
               state_q <= AMU_ST_MEM;
            end
            AMU_ST_MEM: begin
               if (mem_ready) begin
                  rdata_q <= mem_rdata;
                  if (!op_q.store)      state_q <= AMU_ST_WB_REG;
                  else if (has_addr_wb) state_q <= AMU_ST_WB_ADDR;
                  else                  state_q <= AMU_ST_DONE;
               end
            end
            AMU_ST_WB_REG:  state_q <= has_addr_wb ? AMU_ST_WB_ADDR : AMU_ST_DONE;
            AMU_ST_WB_ADDR: state_q <= AMU_ST_DONE;
            default:        state_q <= AMU_ST_IDLE;
         endcase
      end
   end

   // Register-file read index: base register first, then transfer register
   assign rf_rd_addr = (state_q == AMU_ST_RD_ADDR) ? {1'b1, op_q.base_num}
                                                   : {op_q.xfer_is_areg, op_q.xfer_num};

   always_comb begin
      rf_wr_en   = 1'b0;
      rf_wr_addr = {op_q.xfer_is_areg, op_q.xfer_num};
      rf_wr_data = load_res;
      if (state_q == AMU_ST_WB_REG) begin
         rf_wr_en = 1'b1;
      end else if (state_q == AMU_ST_WB_ADDR) begin
         rf_wr_en   = 1'b1;
         rf_wr_addr = {1'b1, op_q.base_num};
         rf_wr_data = {{ADDR_PAD{1'b0}}, an_q};
      end
   end

   assign mem_req   = (state_q == AMU_ST_MEM);
   assign mem_write = op_q.store;
   assign mem_size  = op_q.size;
   assign mem_fc    = fc_q;
   assign mem_super = fc_q[FC_SPACE_BIT];
   assign mem_addr  = ea_q;
   assign mem_wdata = data_q;

   assign busy          = (state_q != AMU_ST_IDLE);
   assign done          = (state_q == AMU_ST_DONE);
   assign exc_priv      = (state_q == AMU_ST_EXC) && (fault_q == AMU_FLT_PRIV);
   assign exc_illegal   = (state_q == AMU_ST_EXC) && (fault_q == AMU_FLT_ILLEGAL);
   assign exc_addr_mode = (state_q == AMU_ST_EXC) && (fault_q == AMU_FLT_MODE);

   a_r2_user_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !supervisor) |=> (exc_priv && !mem_req && !rf_wr_en));
   a_r10_bad_encoding: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && supervisor &&
       (((opcode & AMU_OPC_MASK) != AMU_OPC_MATCH) || opcode[7:6] == 2'b11))
      |=> (exc_illegal && !mem_req));
   a_r11_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && supervisor && ((opcode & AMU_OPC_MASK) == AMU_OPC_MATCH) &&
       opcode[7:6] != 2'b11 && opcode[5:3] != AMU_MODE_IND &&
       opcode[5:3] != AMU_MODE_POST && opcode[5:3] != AMU_MODE_PRE)
      |=> (exc_addr_mode && !mem_req));
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_write) &&
                                   $stable(mem_size) && $stable(mem_fc)));
   a_r12_load_wb_next: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && !mem_write) |=> (rf_wr_en && !mem_req));
   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   a_r12_one_exc: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_priv, exc_illegal, exc_addr_mode, done, mem_req}));

endmodule

// File: tb/altspace_move_unit_tb_top.sv
`timescale 1ns/1ps
module altspace_move_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fcr_wr_en = 1'b0, fcr_sel = 1'b0;
   logic [31:0] fcr_wdata = '0;
   logic [2:0]  fcr_rdata;
   logic        start = 1'b0, supervisor = 1'b0;
   logic [15:0] opcode = '0, ext_word = '0;
   logic        busy, done, exc_priv, exc_illegal, exc_addr_mode;
   logic [3:0]  rf_rd_addr, rf_wr_addr;
   logic [31:0] rf_rd_data, rf_wr_data;
   logic        rf_wr_en;
   logic        mem_req, mem_write, mem_super;
   logic [1:0]  mem_size;
   logic [2:0]  mem_fc;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;

   logic [31:0] regs [16];
   logic [2:0]  sfc_m = '0, dfc_m = '0;
   int checks = 0, errors = 0, cycles = 0;

   always #2 clk = ~clk;

   assign rf_rd_data = regs[rf_rd_addr];
   always @(posedge clk) if (rf_wr_en) regs[rf_wr_addr] <= rf_wr_data;

   altspace_move_unit dut_i (
      .clk(clk), .rst_n(rst_n), .fcr_wr_en(fcr_wr_en), .fcr_sel(fcr_sel),
      .fcr_wdata(fcr_wdata), .fcr_rdata(fcr_rdata), .start(start), .opcode(opcode),
      .ext_word(ext_word), .supervisor(supervisor), .busy(busy), .done(done),
      .exc_priv(exc_priv), .exc_illegal(exc_illegal), .exc_addr_mode(exc_addr_mode),
      .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
      .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data), .mem_req(mem_req),
      .mem_write(mem_write), .mem_size(mem_size), .mem_fc(mem_fc), .mem_super(mem_super),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_step(input logic [1:0] sz, input logic [2:0] an);
      case (sz)
         2'b00:   return (an == 3'd7) ? 32'd2 : 32'd1;
         2'b01:   return 32'd2;
         default: return 32'd4;
      endcase
   endfunction

   function automatic logic [31:0] exp_merge(input logic [1:0] sz, input bit isa,
                                             input logic [31:0] rd, input logic [31:0] old);
      case (sz)
         2'b00:   return isa ? {{24{rd[7]}}, rd[7:0]} : {old[31:8], rd[7:0]};
         2'b01:   return isa ? {{16{rd[15]}}, rd[15:0]} : {old[31:16], rd[15:0]};
         default: return rd;
      endcase
   endfunction

   function automatic logic [15:0] mk_opc(input logic [1:0] sz, input logic [2:0] md,
                                         input logic [2:0] an);
      return 16'h0E00 | {8'h00, sz, md, an};
   endfunction

   function automatic logic [15:0] mk_ext(input bit isa, input logic [2:0] num, input bit st);
      return {isa, num, st, 11'h000};
   endfunction

   task automatic write_fc(input bit sel, input logic [31:0] val);
      @(negedge clk);
      fcr_wr_en = 1'b1; fcr_sel = sel; fcr_wdata = val;
      @(negedge clk);
      fcr_wr_en = 1'b0;
      if (sel) dfc_m = val[2:0]; else sfc_m = val[2:0];
      chk(fcr_rdata == val[2:0], "R1", "fc readback", {29'd0, fcr_rdata}, {29'd0, val[2:0]});
   endtask

   // fault codes: 0 none, 1 privilege, 2 illegal, 3 address mode
   task automatic run_op(input logic [15:0] opc, input logic [15:0] ext, input bit sup,
                         input logic [31:0] rdv, input int wait_in, input string tag);
      logic [31:0] exp_rf [16];
      int          efault, gfault, nreq, ndone, waitc, nbad;
      logic [1:0]  sz;
      logic [2:0]  md, an;
      logic [3:0]  xi;
      bit          st, first;
      logic [31:0] step, ea, efc;
      sz = opc[7:6]; md = opc[5:3]; an = opc[2:0]; st = ext[11];
      xi = {ext[15], ext[14:12]};
      for (int i = 0; i < 16; i++) exp_rf[i] = regs[i];
      if (!sup) efault = 1;
      else if ((opc & 16'hFF00) != 16'h0E00 || sz == 2'b11) efault = 2;
      else if (md != 3'b010 && md != 3'b011 && md != 3'b100) efault = 3;
      else efault = 0;
      step = exp_step(sz, an);
      ea   = (md == 3'b100) ? regs[8 + an] - step : regs[8 + an];
      efc  = {29'd0, st ? dfc_m : sfc_m};
      if (efault == 0) begin
         if (!st) exp_rf[xi] = exp_merge(sz, xi[3], rdv, regs[xi]);
         if (md == 3'b011) exp_rf[8 + an] = ea + step;
         if (md == 3'b100) exp_rf[8 + an] = ea;
      end
      @(negedge clk);
      start = 1'b1; opcode = opc; ext_word = ext; supervisor = sup;
      @(negedge clk);
      start = 1'b0;
      gfault = 0; nreq = 0; ndone = 0; waitc = wait_in; nbad = 0; first = 1'b1;
      for (int c = 0; c < 40; c++) begin
         if (mem_ready) begin
            mem_ready = 1'b0;
         end else if (mem_req) begin
            nreq++;
            if (first) begin
               first = 1'b0;
               chk(mem_addr == ea, tag, "R9 access address", mem_addr, ea);
               chk(mem_write == st && mem_fc == efc[2:0], tag, "R4 direction and code",
                   {27'd0, mem_write, 1'b0, mem_fc}, {27'd0, st, 1'b0, efc[2:0]});
               chk(mem_super == efc[2] && mem_size == sz, tag, "R5 space and size",
                   {29'd0, mem_super, mem_size}, {29'd0, efc[2], sz});
               if (st) chk(mem_wdata == regs[xi], tag, "R4 store data", mem_wdata, regs[xi]);
            end else if (mem_addr != ea || mem_write != st || mem_size != sz) begin
               nbad++;
            end
            if (waitc == 0) begin
               mem_ready = 1'b1; mem_rdata = rdv;
            end else begin
               waitc--;
            end
         end
         if (exc_priv) gfault = 1;
         if (exc_illegal) gfault = 2;
         if (exc_addr_mode) gfault = 3;
         if (done) ndone++;
         if (done || gfault != 0) break;
         @(negedge clk);
      end
      @(negedge clk);
      chk(gfault == efault, tag, "exception kind", gfault, efault);
      chk(nreq == (efault == 0 ? wait_in + 1 : 0) && nbad == 0, "R12", "request cycles",
          nreq, (efault == 0 ? wait_in + 1 : 0));
      chk(ndone == (efault == 0 ? 1 : 0) && !busy, "R12", "done pulse", ndone,
          (efault == 0 ? 1 : 0));
      for (int i = 0; i < 16; i++)
         if (regs[i] !== exp_rf[i]) chk(1'b0, tag, $sformatf("reg %0d", i), regs[i], exp_rf[i]);
      chk(1'b1, tag, "register file", 0, 0);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL R12 watchdog actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin : stim
      void'($urandom(32'h1357_2468));
      for (int i = 0; i < 16; i++) regs[i] = $urandom;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req && !done && !rf_wr_en, "R12", "reset idle",
          {28'd0, busy, mem_req, done, rf_wr_en}, 0);
      fcr_sel = 1'b0; #0;
      chk(fcr_rdata == 0, "R1", "source reset", {29'd0, fcr_rdata}, 0);
      fcr_sel = 1'b1; #0;
      chk(fcr_rdata == 0, "R1", "destination reset", {29'd0, fcr_rdata}, 0);

      write_fc(1'b0, 32'hFFFF_FFF5);
      write_fc(1'b1, 32'h0000_000A);

      // R7 byte load into data register, supervisor space code
      regs[3] = 32'h1122_3344; regs[10] = 32'h0000_1000;
      run_op(mk_opc(2'b00, 3'b010, 3'd2), mk_ext(1'b0, 3'd3, 1'b0), 1'b1, 32'hAABB_CC80, 0, "R7");
      chk(regs[3] == 32'h1122_3380, "R7", "byte merge", regs[3], 32'h1122_3380);
      // R6 word load into address register, postincrement
      regs[14] = 32'h0000_4000;
      run_op(mk_opc(2'b01, 3'b011, 3'd6), mk_ext(1'b1, 3'd4, 1'b0), 1'b1, 32'h0000_8001, 2, "R6");
      chk(regs[12] == 32'hFFFF_8001, "R6", "sign extend", regs[12], 32'hFFFF_8001);
      // R7 word load into data register keeps upper half
      regs[2] = 32'hDEAD_BEEF;
      run_op(mk_opc(2'b01, 3'b010, 3'd2), mk_ext(1'b0, 3'd2, 1'b0), 1'b1, 32'h1234_5678, 1, "R7");
      // R9 long store predecrement, user-space destination code
      regs[13] = 32'h0000_2000; regs[1] = 32'hCAFE_F00D;
      run_op(mk_opc(2'b10, 3'b100, 3'd5), mk_ext(1'b0, 3'd1, 1'b1), 1'b1, 32'h0, 0, "R9");
      chk(regs[13] == 32'h0000_1FFC, "R9", "predecrement write-back", regs[13], 32'h1FFC);
      // R8 stack register byte step of 2, ordinary byte step of 1, long step
      regs[15] = 32'h0000_3001;
      run_op(mk_opc(2'b00, 3'b011, 3'd7), mk_ext(1'b0, 3'd0, 1'b1), 1'b1, 32'h0, 0, "R8");
      chk(regs[15] == 32'h0000_3003, "R8", "stack byte step", regs[15], 32'h3003);
      regs[11] = 32'h0000_5000;
      run_op(mk_opc(2'b00, 3'b011, 3'd3), mk_ext(1'b0, 3'd5, 1'b0), 1'b1, 32'h0000_0077, 0, "R8");
      chk(regs[11] == 32'h0000_5001, "R8", "byte step", regs[11], 32'h5001);
      run_op(mk_opc(2'b00, 3'b100, 3'd7), mk_ext(1'b1, 3'd0, 1'b0), 1'b1, 32'h0000_00F0, 3, "R9");
      run_op(mk_opc(2'b10, 3'b011, 3'd0), mk_ext(1'b1, 3'd3, 1'b0), 1'b1, 32'h8765_4321, 3, "R3");
      // R2 user mode, also over a bad size (privilege wins)
      run_op(mk_opc(2'b10, 3'b010, 3'd1), mk_ext(1'b0, 3'd1, 1'b0), 1'b0, 32'h0, 0, "R2");
      run_op(mk_opc(2'b11, 3'b000, 3'd1), mk_ext(1'b0, 3'd1, 1'b1), 1'b0, 32'h0, 0, "R2");
      // R10 bad size and foreign opcode
      run_op(mk_opc(2'b11, 3'b010, 3'd1), mk_ext(1'b0, 3'd1, 1'b0), 1'b1, 32'h0, 0, "R10");
      run_op(16'h0F10, mk_ext(1'b0, 3'd1, 1'b0), 1'b1, 32'h0, 0, "R10");
      // R11 data-register direct and displacement modes
      run_op(mk_opc(2'b01, 3'b000, 3'd1), mk_ext(1'b0, 3'd2, 1'b0), 1'b1, 32'h0, 0, "R11");
      run_op(mk_opc(2'b10, 3'b101, 3'd4), mk_ext(1'b1, 3'd2, 1'b1), 1'b1, 32'h0, 0, "R11");
      // R12 start while busy is ignored
      regs[9] = 32'h0000_6000;
      @(negedge clk);
      start = 1'b1; opcode = mk_opc(2'b10, 3'b010, 3'd1); ext_word = mk_ext(1'b0, 3'd6, 1'b0);
      supervisor = 1'b1;
      @(negedge clk);
      opcode = mk_opc(2'b10, 3'b011, 3'd1);
      @(negedge clk);
      @(negedge clk);
      chk(mem_req && mem_addr == 32'h6000, "R12", "restart while busy", mem_addr, 32'h6000);
      start = 1'b0; mem_ready = 1'b1; mem_rdata = 32'h0BAD_F00D;
      @(negedge clk);
      mem_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(regs[9] == 32'h6000 && regs[6] == 32'h0BAD_F00D && !busy, "R12", "busy start ignored",
          regs[9], 32'h6000);

      // R4 constrained random mix
      for (int n = 0; n < 80; n++) begin
         logic [1:0] rsz;
         logic [2:0] rmd;
         if ($urandom_range(0, 9) == 0) write_fc($urandom_range(0, 1), $urandom);
         rsz = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
         rmd = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'($urandom_range(2, 4));
         run_op(mk_opc(rsz, rmd, 3'($urandom)),
                {1'($urandom), 3'($urandom), 1'($urandom), 11'($urandom)},
                ($urandom_range(0, 9) != 0), $urandom, $urandom_range(0, 3), "R4");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule